// File: doc/BRIEF.md
# DMA Bus to Byte FIFO Bridge

This block joins an external DMA data bus, 8 or 16 bits wide, to a 16-entry byte FIFO whose far side belongs to a serial byte engine. It raises a request whenever the FIFO can take or supply a transfer and moves data once per acknowledge cycle. Each byte carries its own parity bit. The parity bit is stored next to its byte and returned unchanged.

Two static pins pick one of four bus configurations:

| Code | Width | Read strobe |
|------|-------|-------------|
| 0 | 8-bit | shared read line |
| 1 | 16-bit | shared read line |
| 2 | 16-bit | dedicated DMA read line; optional per-lane byte control |
| 3 | 16-bit | no read line; each new assertion of the acknowledge is one read |

A direction input selects the flow. DMA writes fill the FIFO and the byte side drains it, or the byte side fills the FIFO and DMA reads drain it. A 24-bit transfer counter limits the total number of bytes moved.

All inputs are sampled on the rising clock edge and all strobes are active low. A strobe counts as a transfer in the first cycle it is seen low while the acknowledge is also low.

Top module: `dma_fifo_bridge`

## Requirements
- R1: After reset the FIFO level is 0, the remaining count is 0 and the request is low.
- R2: In mode 0 (mode pins = 0) every accepted transfer moves one byte, on lane 0 (bits 7:0, parity bit 0), and lowers the count by 1.
- R3: In modes 1 and 3, and in mode 2 with byte control off, an accepted write pushes the low lane (bits 7:0) first and then the high lane (bits 15:8). A read presents the oldest byte on the low lane and the next byte on the high lane.
- R4: The parity bit of each lane (bit 0 for low, bit 1 for high) travels with its byte and comes out unchanged on the opposite side.
- R5: Modes 0 and 1 use the shared read line as the read strobe and mode 2 uses the dedicated read line. A falling edge on the other read line has no effect.
- R6: In mode 3 a read happens on each high-to-low change of the acknowledge. Holding the acknowledge low gives exactly one read, and both read lines are ignored.
- R7: In mode 2 with byte control on, the high lane is used when the high-enable input is 1 and the low lane is used when address bit 0 is 0. With high-enable 0 and address bit 0 at 1 nothing moves. A lone high lane is pushed, or presented, as the single byte.
- R8: In the write direction the request is high when the count is non-zero and the free space is at least the need. The need is 1 byte in mode 0 and in mode 2 with byte control, and 2 bytes otherwise.
- R9: In the read direction the request is high when the count is non-zero and the FIFO holds at least the need.
- R10: With the count at zero the request is low and strobes move no data. A transfer that needs more space or data than is present is also ignored.
- R11: A load sets the count. Each accepted transfer lowers the count by the number of bytes moved, stopping at zero.
- R12: A byte-side pop while the FIFO is empty is ignored, and a byte-side push while it is full is ignored. The level never exceeds 16.
- R13: A strobe while the acknowledge is high moves nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Static bus configuration code 0..3 |
| byte_ctl_en_i | input | 1 | Enables byte-lane control in mode 2 |
| dir_to_fifo_i | input | 1 | 1: DMA writes into FIFO; 0: DMA reads from FIFO |
| dack_n_i | input | 1 | DMA acknowledge, active low |
| rd_shared_n_i | input | 1 | Shared read strobe, active low |
| rd_dma_n_i | input | 1 | Dedicated DMA read strobe, active low |
| wr_n_i | input | 1 | DMA write strobe, active low |
| bhe_i | input | 1 | High lane enable for byte control |
| a0_i | input | 1 | Address bit 0 for byte control (1 disables low lane) |
| db_i | input | 16 | DMA write data |
| dbp_i | input | 2 | DMA write parity, one per lane |
| db_o | output | 16 | DMA read data |
| dbp_o | output | 2 | DMA read parity, one per lane |
| dreq_o | output | 1 | DMA request |
| cnt_load_i | input | 1 | Loads the transfer counter |
| cnt_val_i | input | 24 | Value loaded into the counter |
| cnt_left_o | output | 24 | Remaining transfer count |
| sc_push_i | input | 1 | Byte-side push (read direction) |
| sc_byte_i | input | 8 | Byte-side push data |
| sc_par_i | input | 1 | Byte-side push parity |
| sc_pop_i | input | 1 | Byte-side pop (write direction) |
| sc_byte_o | output | 8 | Oldest FIFO byte |
| sc_par_o | output | 1 | Parity of oldest FIFO byte |
| level_o | output | 5 | FIFO occupancy in bytes |

## Verification
The assertions assume that the mode pins and the direction stay fixed between resets. They also assume that a byte-side push or pop does not share a cycle with an acknowledge window. The level and counter bounds hold only under that usage. The stimulus changes mode and direction only inside a reset. It serializes every operation into its own strobe window, drops each strobe and acknowledge for one clock, and returns them high before the next operation. Random runs mix all four modes, both directions, byte-control settings and counter reloads, including reloads to zero.

// File: rtl/dfb_pkg.sv
package dfb_pkg;

    typedef enum logic [1:0] {
        MODE_NARROW   = 2'd0,
        MODE_WIDE     = 2'd1,
        MODE_SPLIT_BC = 2'd2,
        MODE_SPLIT    = 2'd3
    } bus_mode_e;

    // one FIFO entry: byte plus its parity bit
    typedef struct packed {
        logic [7:0] data;
        logic       par;
    } fbyte_t;

    // active lanes of one DMA cycle
    typedef struct packed {
        logic hi;
        logic lo;
    } lanes_t;

    function automatic logic [1:0] lane_count(lanes_t l);
        return {1'b0, l.hi} + {1'b0, l.lo};
    endfunction

endpackage

// File: rtl/dfb_strobe_sel.sv
module dfb_strobe_sel
    import dfb_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    input  logic       byte_ctl_en_i,
    input  logic       dir_to_fifo_i,
    input  logic       dack_n_i,
    input  logic       rd_shared_n_i,
    input  logic       rd_dma_n_i,
    input  logic       wr_n_i,
    input  logic       bhe_i,
    input  logic       a0_i,
    output logic       evt_o,
    output lanes_t     lanes_o,
    output logic [1:0] need_o
);

    typedef struct packed {
        logic dack;
        logic rds;
        logic rdd;
        logic wr;
    } prev_t;

    prev_t     s_d, s_q;
    bus_mode_e mode;
    logic      rd_now_n, rd_prev_n;
    logic      rd_evt, wr_evt;

    assign mode = bus_mode_e'(mode_i);

    always_comb begin
        s_d.dack = dack_n_i;
        s_d.rds  = rd_shared_n_i;
        s_d.rdd  = rd_dma_n_i;
        s_d.wr   = wr_n_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '1;
        else         s_q <= s_d;
    end

    // read strobe source depends on configuration
    always_comb begin
        rd_now_n  = rd_shared_n_i;
        rd_prev_n = s_q.rds;
        if (mode == MODE_SPLIT_BC) begin
            rd_now_n  = rd_dma_n_i;
            rd_prev_n = s_q.rdd;
        end
    end

    always_comb begin
        if (mode == MODE_SPLIT) rd_evt = !dack_n_i && s_q.dack;
        else                    rd_evt = !dack_n_i && !rd_now_n && rd_prev_n;
        wr_evt = !dack_n_i && !wr_n_i && s_q.wr;
        evt_o  = dir_to_fifo_i ? wr_evt : rd_evt;
    end

    always_comb begin
        lanes_o = '{hi: 1'b1, lo: 1'b1};
        need_o  = 2'd2;
        if (mode == MODE_NARROW) begin
            lanes_o = '{hi: 1'b0, lo: 1'b1};
            need_o  = 2'd1;
        end else if (mode == MODE_SPLIT_BC && byte_ctl_en_i) begin
            lanes_o = '{hi: bhe_i, lo: !a0_i};
            need_o  = 2'd1;
        end
    end

endmodule

// File: rtl/dfb_fifo.sv
module dfb_fifo
    import dfb_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       wr_cnt_i,
    input  fbyte_t           wr_b0_i,
    input  fbyte_t           wr_b1_i,
    input  logic [1:0]       rd_cnt_i,
    output fbyte_t           head0_o,
    output fbyte_t           head1_o,
    output logic [LVL_W-1:0] level_o
);

    localparam logic [PTR_W:0] DEPTH_P = (PTR_W + 1)'(DEPTH);

    typedef struct packed {
        fbyte_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   wr_ptr;
        logic [PTR_W-1:0]   rd_ptr;
        logic [LVL_W-1:0]   level;
    } fifo_st_t;

    fifo_st_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_add(logic [PTR_W-1:0] p, logic [1:0] n);
        logic [PTR_W:0] sum;
        sum = {1'b0, p} + {{(PTR_W - 1){1'b0}}, n};
        if (sum >= DEPTH_P) sum = sum - DEPTH_P;
        return sum[PTR_W-1:0];
    endfunction

    always_comb begin
        s_d = s_q;
        if (wr_cnt_i != 2'd0) s_d.mem[s_q.wr_ptr] = wr_b0_i;
        if (wr_cnt_i == 2'd2) s_d.mem[ptr_add(s_q.wr_ptr, 2'd1)] = wr_b1_i;
        s_d.wr_ptr = ptr_add(s_q.wr_ptr, wr_cnt_i);
        s_d.rd_ptr = ptr_add(s_q.rd_ptr, rd_cnt_i);
        s_d.level  = s_q.level + {{(LVL_W - 2){1'b0}}, wr_cnt_i}
                               - {{(LVL_W - 2){1'b0}}, rd_cnt_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign head0_o = s_q.mem[s_q.rd_ptr];
    assign head1_o = s_q.mem[ptr_add(s_q.rd_ptr, 2'd1)];
    assign level_o = s_q.level;

endmodule

// File: rtl/dfb_xfer_cnt.sv
module dfb_xfer_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [1:0]       dec_i,
    output logic [CNT_W-1:0] left_o
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
    } cnt_st_t;

    cnt_st_t          s_d, s_q;
    logic [CNT_W-1:0] dec_ext;

    assign dec_ext = {{(CNT_W - 2){1'b0}}, dec_i};

    always_comb begin
        s_d = s_q;
        if (load_i)                  s_d.left = load_val_i;
        else if (dec_ext > s_q.left) s_d.left = '0;
        else                         s_d.left = s_q.left - dec_ext;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign left_o = s_q.left;

endmodule

// File: rtl/dma_fifo_bridge.sv
module dma_fifo_bridge
    import dfb_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int CNT_W = 24,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       mode_i,
    input  logic             byte_ctl_en_i,
    input  logic             dir_to_fifo_i,
    input  logic             dack_n_i,
    input  logic             rd_shared_n_i,
    input  logic             rd_dma_n_i,
    input  logic             wr_n_i,
    input  logic             bhe_i,
    input  logic             a0_i,
    input  logic [15:0]      db_i,
    input  logic [1:0]       dbp_i,
    output logic [15:0]      db_o,
    output logic [1:0]       dbp_o,
    output logic             dreq_o,
    input  logic             cnt_load_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    output logic [CNT_W-1:0] cnt_left_o,
    input  logic             sc_push_i,
    input  logic [7:0]       sc_byte_i,
    input  logic             sc_par_i,
    input  logic             sc_pop_i,
    output logic [7:0]       sc_byte_o,
    output logic             sc_par_o,
    output logic [LVL_W-1:0] level_o
);

    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    logic             evt;
    lanes_t           lanes;
    logic [1:0]       need, moves, wr_cnt, rd_cnt, dec;
    logic [LVL_W-1:0] level, free, moves_l, need_l;
    logic             dma_ok, room_ok;
    fbyte_t           in_lo, in_hi, in_sc, b0, b1, head0, head1, out_lo, out_hi;

    dfb_strobe_sel strobe_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .mode_i        (mode_i),
        .byte_ctl_en_i (byte_ctl_en_i),
        .dir_to_fifo_i (dir_to_fifo_i),
        .dack_n_i      (dack_n_i),
        .rd_shared_n_i (rd_shared_n_i),
        .rd_dma_n_i    (rd_dma_n_i),
        .wr_n_i        (wr_n_i),
        .bhe_i         (bhe_i),
        .a0_i          (a0_i),
        .evt_o         (evt),
        .lanes_o       (lanes),
        .need_o        (need)
    );

    dfb_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_cnt_i (wr_cnt),
        .wr_b0_i  (b0),
        .wr_b1_i  (b1),
        .rd_cnt_i (rd_cnt),
        .head0_o  (head0),
        .head1_o  (head1),
        .level_o  (level)
    );

    dfb_xfer_cnt #(.CNT_W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load_i),
        .load_val_i (cnt_val_i),
        .dec_i      (dec),
        .left_o     (cnt_left_o)
    );

    assign in_lo = '{data: db_i[7:0],  par: dbp_i[0]};
    assign in_hi = '{data: db_i[15:8], par: dbp_i[1]};
    assign in_sc = '{data: sc_byte_i,  par: sc_par_i};

    always_comb begin
        moves   = lane_count(lanes);
        moves_l = {{(LVL_W - 2){1'b0}}, moves};
        need_l  = {{(LVL_W - 2){1'b0}}, need};
        free    = DEPTH_L - level;
        room_ok = dir_to_fifo_i ? (free >= moves_l) : (level >= moves_l);
        dma_ok  = evt && (cnt_left_o != '0) && (moves != 2'd0) && room_ok;
        dec     = dma_ok ? moves : 2'd0;
        dreq_o  = (cnt_left_o != '0) &&
                  (dir_to_fifo_i ? (free >= need_l) : (level >= need_l));
    end

    // FIFO port steering by direction
    always_comb begin
        if (dir_to_fifo_i) begin
            wr_cnt = dec;
            b0     = lanes.lo ? in_lo : in_hi;
            b1     = in_hi;
            rd_cnt = (sc_pop_i && level != '0) ? 2'd1 : 2'd0;
        end else begin
            wr_cnt = (sc_push_i && level != DEPTH_L) ? 2'd1 : 2'd0;
            b0     = in_sc;
            b1     = in_sc;
            rd_cnt = dec;
        end
    end

    always_comb begin
        out_lo = lanes.lo ? head0 : '0;
        out_hi = lanes.hi ? (lanes.lo ? head1 : head0) : '0;
        db_o   = {out_hi.data, out_lo.data};
        dbp_o  = {out_hi.par, out_lo.par};
    end

    assign sc_byte_o = head0.data;
    assign sc_par_o  = head0.par;
    assign level_o   = level;

endmodule

// File: rtl/dfb_checker.sv
module dfb_checker #(
    parameter  int DEPTH = 16,
    parameter  int CNT_W = 24,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       mode_i,
    input logic             dir_to_fifo_i,
    input logic             dack_n_i,
    input logic             sc_push_i,
    input logic             sc_pop_i,
    input logic             cnt_load_i,
    input logic [CNT_W-1:0] cnt_left_o,
    input logic [LVL_W-1:0] level_o,
    input logic             dreq_o
);

    a_r12_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= LVL_W'(DEPTH));

    a_r10_no_req_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_left_o == '0) |-> !dreq_o);

    a_r11_count_never_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt_load_i |=> (cnt_left_o <= $past(cnt_left_o)));

    a_r13_idle_ack_holds_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dack_n_i && !sc_push_i && !sc_pop_i) |=> $stable(level_o));

    a_r2_narrow_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 2'd0 && dir_to_fifo_i && !sc_pop_i) |=>
        ({1'b0, level_o} <= {1'b0, $past(level_o)} + 1'b1));

    a_r8_req_means_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dreq_o && dir_to_fifo_i) |-> (level_o < LVL_W'(DEPTH)));

endmodule

bind dma_fifo_bridge dfb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .mode_i        (mode_i),
    .dir_to_fifo_i (dir_to_fifo_i),
    .dack_n_i      (dack_n_i),
    .sc_push_i     (sc_push_i),
    .sc_pop_i      (sc_pop_i),
    .cnt_load_i    (cnt_load_i),
    .cnt_left_o    (cnt_left_o),
    .level_o       (level_o),
    .dreq_o        (dreq_o)
);

// File: tb/dma_fifo_bridge_tb_top.sv
module dma_fifo_bridge_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        bc = 1'b0, dir = 1'b1;
    logic        dack_n = 1'b1, rds_n = 1'b1, rdd_n = 1'b1, wr_n = 1'b1;
    logic        bhe = 1'b0, a0 = 1'b0;
    logic [15:0] db_in = '0;
    logic [1:0]  dbp_in = '0;
    logic [15:0] db_out;
    logic [1:0]  dbp_out;
    logic        dreq;
    logic        cnt_load = 1'b0;
    logic [23:0] cnt_val = '0;
    logic [23:0] cnt_left;
    logic        sc_push = 1'b0, sc_par = 1'b0, sc_pop = 1'b0;
    logic [7:0]  sc_byte = '0;
    logic [7:0]  sc_byte_out;
    logic        sc_par_out;
    logic [4:0]  level;

    dma_fifo_bridge dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .byte_ctl_en_i(bc),
        .dir_to_fifo_i(dir), .dack_n_i(dack_n), .rd_shared_n_i(rds_n),
        .rd_dma_n_i(rdd_n), .wr_n_i(wr_n), .bhe_i(bhe), .a0_i(a0),
        .db_i(db_in), .dbp_i(dbp_in), .db_o(db_out), .dbp_o(dbp_out),
        .dreq_o(dreq), .cnt_load_i(cnt_load), .cnt_val_i(cnt_val),
        .cnt_left_o(cnt_left), .sc_push_i(sc_push), .sc_byte_i(sc_byte),
        .sc_par_i(sc_par), .sc_pop_i(sc_pop), .sc_byte_o(sc_byte_out),
        .sc_par_o(sc_par_out), .level_o(level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    logic [8:0] mq[$];   // model entry: {parity, byte}
    int left = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // {hi, lo} lanes from the requirements R2, R3, R7
    function automatic logic [1:0] lanes_of(logic h, logic a);
        if (mode == 2'd0) return 2'b01;
        if (mode == 2'd2 && bc) return {h, !a};
        return 2'b11;
    endfunction

    function automatic int need_of();
        return (mode == 2'd0 || (mode == 2'd2 && bc)) ? 1 : 2;
    endfunction

    task automatic check_state(string req);
        bit exp_req;
        exp_req = (left != 0) && (dir ? (DEPTH - mq.size() >= need_of())
                                      : (mq.size() >= need_of()));
        check({req, " level"}, int'(level), mq.size());
        check({req, " count"}, int'(cnt_left), left);
        check({req, " dreq"}, int'(dreq), int'(exp_req));
    endtask

    task automatic apply_reset(logic [1:0] m, logic b, logic d);
        @(negedge clk);
        rst_n = 1'b0; mode = m; bc = b; dir = d;
        dack_n = 1'b1; rds_n = 1'b1; rdd_n = 1'b1; wr_n = 1'b1;
        sc_push = 1'b0; sc_pop = 1'b0; cnt_load = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mq.delete();
        left = 0;
        @(negedge clk);
    endtask

    task automatic load_cnt(int v);
        cnt_load = 1'b1; cnt_val = 24'(v);
        @(negedge clk);
        cnt_load = 1'b0;
        left = v;
    endtask

    task automatic dma_write(logic [7:0] lo, logic [7:0] hi, logic [1:0] p,
                             logic h, logic a, bit ack);
        logic [1:0] l;
        int mv;
        db_in = {hi, lo}; dbp_in = p; bhe = h; a0 = a;
        wr_n = 1'b0; dack_n = !ack;
        @(negedge clk);
        wr_n = 1'b1; dack_n = 1'b1;
        l = lanes_of(h, a);
        mv = int'(l[0]) + int'(l[1]);
        if (ack && left > 0 && mv > 0 && DEPTH - mq.size() >= mv) begin
            if (l[0]) mq.push_back({p[0], lo});
            if (l[1]) mq.push_back({p[1], hi});
            left = (left > mv) ? left - mv : 0;
        end
        @(negedge clk);
    endtask

    task automatic dma_read(logic h, logic a, string req);
        logic [1:0] l;
        int mv;
        bit ok;
        bhe = h; a0 = a;
        #1;
        l = lanes_of(h, a);
        mv = int'(l[0]) + int'(l[1]);
        ok = mv > 0 && mq.size() >= mv;
        if (ok) begin
            check({req, " rd lo"}, int'({dbp_out[0], db_out[7:0]}),
                  l[0] ? int'(mq[0]) : 0);
            check({req, " rd hi"}, int'({dbp_out[1], db_out[15:8]}),
                  l[1] ? int'(l[0] ? mq[1] : mq[0]) : 0);
        end
        @(negedge clk);
        dack_n = 1'b0;
        if (mode == 2'd0 || mode == 2'd1) rds_n = 1'b0;
        else if (mode == 2'd2) rdd_n = 1'b0;
        @(negedge clk);
        dack_n = 1'b1; rds_n = 1'b1; rdd_n = 1'b1;
        if (ok && left > 0) begin
            for (int i = 0; i < mv; i++) void'(mq.pop_front());
            left = (left > mv) ? left - mv : 0;
        end
        @(negedge clk);
    endtask

    // wrong read line pulsed with the acknowledge low (R5)
    task automatic stray_read(bit use_shared);
        dack_n = 1'b0;
        if (use_shared) rds_n = 1'b0; else rdd_n = 1'b0;
        @(negedge clk);
        dack_n = 1'b1; rds_n = 1'b1; rdd_n = 1'b1;
        @(negedge clk);
    endtask

    // mode 3: acknowledge held low for several cycles, read lines toggled (R6)
    task automatic ack_hold(int n);
        int mv;
        mv = 2;
        dack_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            rds_n = i[0]; rdd_n = i[0];
            @(negedge clk);
        end
        dack_n = 1'b1; rds_n = 1'b1; rdd_n = 1'b1;
        if (mq.size() >= mv && left > 0) begin
            for (int i = 0; i < mv; i++) void'(mq.pop_front());
            left = (left > mv) ? left - mv : 0;
        end
        @(negedge clk);
    endtask

    task automatic sc_do_pop(string req);
        if (mq.size() > 0)
            check({req, " sc out"}, int'({sc_par_out, sc_byte_out}), int'(mq[0]));
        sc_pop = 1'b1;
        @(negedge clk);
        sc_pop = 1'b0;
        if (mq.size() > 0) void'(mq.pop_front());
    endtask

    task automatic sc_do_push(logic [7:0] b, logic p);
        sc_push = 1'b1; sc_byte = b; sc_par = p;
        @(negedge clk);
        sc_push = 1'b0;
        if (mq.size() < DEPTH) mq.push_back({p, b});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset state
        apply_reset(2'd0, 1'b0, 1'b1);
        check("R1 level", int'(level), 0);
        check("R1 count", int'(cnt_left), 0);
        check("R1 dreq", int'(dreq), 0);

        // R10: count zero blocks request and data
        dma_write(8'hA5, 8'h00, 2'b01, 1'b0, 1'b0, 1'b1);
        check_state("R10");

        // R2, R4: narrow writes, byte order and parity
        load_cnt(40);
        dma_write(8'h11, 8'hFF, 2'b11, 1'b0, 1'b0, 1'b1);
        dma_write(8'h22, 8'hFF, 2'b00, 1'b0, 1'b0, 1'b1);
        dma_write(8'h33, 8'hFF, 2'b01, 1'b0, 1'b0, 1'b1);
        check_state("R2");
        // R13: strobe with acknowledge high
        dma_write(8'h44, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0);
        check_state("R13");
        sc_do_pop("R4"); sc_do_pop("R2"); sc_do_pop("R4");
        // R12: pop from empty FIFO
        sc_do_pop("R12");
        check_state("R12");

        // R3, R4, R8: wide writes fill to 16, request withdrawn
        apply_reset(2'd1, 1'b0, 1'b1);
        load_cnt(100);
        for (int i = 0; i < 7; i++)
            dma_write(8'(2 * i), 8'(2 * i + 1), 2'(i), 1'b0, 1'b0, 1'b1);
        check_state("R8");
        dma_write(8'hE0, 8'hE1, 2'b10, 1'b0, 1'b0, 1'b1);
        check_state("R8");
        // R10: transfer with too little space ignored (level 15 needs 2)
        sc_do_pop("R3");
        dma_write(8'hF0, 8'hF1, 2'b11, 1'b0, 1'b0, 1'b1);
        check_state("R10");
        sc_do_pop("R3"); sc_do_pop("R4");
        check_state("R8");

        // R11: count decrements by moved bytes, saturates
        apply_reset(2'd1, 1'b0, 1'b1);
        load_cnt(3);
        dma_write(8'h01, 8'h02, 2'b00, 1'b0, 1'b0, 1'b1);
        check_state("R11");
        dma_write(8'h03, 8'h04, 2'b00, 1'b0, 1'b0, 1'b1);
        check_state("R11");

        // R5, R9, R12: read direction, shared line in mode 1
        apply_reset(2'd1, 1'b0, 1'b0);
        load_cnt(50);
        for (int i = 0; i < 17; i++) sc_do_push(8'(8'h80 + i), i[0]);
        check_state("R12");
        stray_read(1'b0);
        check_state("R5");
        dma_read(1'b0, 1'b0, "R3");
        check_state("R9");

        // R5: dedicated line in mode 2, shared line ignored
        apply_reset(2'd2, 1'b0, 1'b0);
        load_cnt(50);
        sc_do_push(8'h5A, 1'b1);
        check_state("R9");
        sc_do_push(8'hC3, 1'b0);
        stray_read(1'b1);
        check_state("R5");
        dma_read(1'b0, 1'b0, "R5");
        check_state("R5");

        // R6: mode 3 acknowledge toggling
        apply_reset(2'd3, 1'b0, 1'b0);
        load_cnt(50);
        for (int i = 0; i < 6; i++) sc_do_push(8'(8'h30 + i), i[1]);
        ack_hold(4);
        check_state("R6");
        dma_read(1'b0, 1'b0, "R6");
        check_state("R6");

        // R7: byte control lane decode in both directions
        apply_reset(2'd2, 1'b1, 1'b1);
        load_cnt(50);
        dma_write(8'h71, 8'h72, 2'b10, 1'b1, 1'b1, 1'b1);
        dma_write(8'h73, 8'h74, 2'b01, 1'b0, 1'b0, 1'b1);
        dma_write(8'h75, 8'h76, 2'b11, 1'b0, 1'b1, 1'b1);
        check_state("R7");
        dma_write(8'h77, 8'h78, 2'b01, 1'b1, 1'b0, 1'b1);
        sc_do_pop("R7"); sc_do_pop("R7"); sc_do_pop("R7"); sc_do_pop("R7");
        apply_reset(2'd2, 1'b1, 1'b0);
        load_cnt(50);
        for (int i = 0; i < 4; i++) sc_do_push(8'(8'h60 + i), i[0]);
        dma_read(1'b1, 1'b1, "R7");
        dma_read(1'b0, 1'b1, "R7");
        check_state("R7");
        dma_read(1'b0, 1'b0, "R7");
        dma_read(1'b1, 1'b0, "R7");
        check_state("R7");

        // random phases over all modes and directions
        for (int r = 0; r < 8; r++) begin
            apply_reset(2'(r % 4), 1'($urandom), 1'($urandom));
            load_cnt(20 + int'($urandom % 40));
            for (int k = 0; k < 150; k++) begin
                int op;
                op = int'($urandom % 6);
                if (op < 3) begin
                    if (dir) dma_write(8'($urandom), 8'($urandom), 2'($urandom),
                                       1'($urandom), 1'($urandom), ($urandom % 8) != 0);
                    else     dma_read(1'($urandom), 1'($urandom), "R3");
                end else if (op < 5) begin
                    if (dir) sc_do_pop("R4");
                    else     sc_do_push(8'($urandom), 1'($urandom));
                end else begin
                    load_cnt(int'($urandom % 30));
                end
                check_state("R11");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule